// File: doc/BRIEF.md
# Master-clocked serial result readout

This block sends a converter's 16-bit result out over a three-wire serial link that it clocks itself. It produces a frame strobe (SYNC), a serial clock (SCLK) and the data line (SDOUT). The word goes out most significant bit first, one bit per SCLK period, for exactly sixteen periods. SCLK stays idle outside the frame. Outputs are launched on the falling SCLK edge, so a receiver samples on the rising edge.

Two read modes exist. In read-after-convert mode, the frame starts when the conversion sequencer signals that a conversion is done. The frame carries that fresh result. A busy-hold output tells the sequencer to keep its conversion-busy indication high until the frame is over. In read-during-convert mode, the frame starts a fixed delay after the convert strobe. It carries the result of the previous conversion while the new conversion runs.

A 2-bit rate select slows SCLK, but only in read-after-convert mode. Two polarity inputs invert SYNC and SCLK independently. An active-low chip select controls the output enables of all three serial pins. The enables are separate signals, not tri-state nets.

Top module: `ser_master_rd`

## Requirements
- R1: In read-after-convert mode (`rd_during`=0), a `conv_done` pulse sampled while idle starts a frame in the next cycle. The frame opens with one lead cycle: SYNC active, SCLK low, SDOUT showing bit 15. Then come 16 SCLK periods. Each period is a low half followed by a high half. Bit 15-k is on SDOUT throughout period k (MSB first).
- R2: In read-after-convert mode, each SCLK half period lasts 1, 2, 4 or 8 clock cycles for `div_sel` = 0, 1, 2 and 3 respectively. `div_sel` is sampled when the frame starts.
- R3: In read-during-convert mode (`rd_during`=1), a `conv_start` pulse sampled while idle waits SYNC_DLY cycles (default 4), and then starts the frame with its lead cycle. SCLK always uses 1-cycle halves in this mode, whatever `div_sel` is. The frame carries the result stored before the strobe.
- R4: After the last SCLK high half, SYNC stays active for exactly one more cycle with SCLK low and SDOUT holding bit 0. After that, SYNC is inactive. Outside a frame, SCLK is low, SYNC is inactive and SDOUT is 0 (polarity inputs low).
- R5: In read-after-convert mode, `hold_busy_o` is high from the lead cycle until one cycle after SYNC goes inactive, and low otherwise. In read-during-convert mode it stays low.
- R6: `sync_inv`=1 makes SYNC active low. `sclk_inv`=1 inverts SCLK. Both act combinationally and independently.
- R7: `sync_oe`, `sclk_oe` and `sdout_oe` are all 1 while `cs_n`=0 and all 0 while `cs_n`=1. Chip select does not stop an internal frame.
- R8: `conv_start` and `conv_done` pulses that arrive while a frame (including its delay and release cycles) is in progress do not restart or alter it.
- R9: While reset (`rst_n`=0) is held, and after it is released, the block is idle: SYNC inactive, SCLK low, SDOUT 0, `hold_busy_o` 0.
- R10: Every `conv_done` pulse, in either mode and at any time, updates the stored result that the next read-during-convert frame sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one cycle is the shortest SCLK half period |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; drives the three output enables |
| conv_start | input | 1 | Convert strobe, one-cycle pulse |
| conv_done | input | 1 | Conversion complete, one-cycle pulse with `result_i` valid |
| result_i | input | 16 | New conversion result |
| rd_during | input | 1 | 1: read during convert, 0: read after convert |
| div_sel | input | 2 | SCLK slow-down select (after-convert mode only) |
| sync_inv | input | 1 | 1 makes SYNC active low |
| sclk_inv | input | 1 | 1 inverts SCLK |
| sync_o | output | 1 | Frame strobe |
| sclk_o | output | 1 | Generated serial clock |
| sdout_o | output | 1 | Serial data |
| sync_oe | output | 1 | Output enable for SYNC |
| sclk_oe | output | 1 | Output enable for SCLK |
| sdout_oe | output | 1 | Output enable for SDOUT |
| hold_busy_o | output | 1 | Tells the sequencer to keep BUSY high |

## Verification
A trigger sampled on clock edge k shows its first effect in the cycle after edge k. That effect is the lead cycle in after-convert mode, or the first of SYNC_DLY idle delay cycles in during-convert mode. From there, the whole frame is fixed cycle by cycle: 32·2^div_sel shift cycles, one tail cycle, and one release cycle in after-convert mode only. The bench builds this expected cycle sequence in a queue at the edge that accepts the trigger and takes one entry off per edge. It compares every output a quarter period after each falling edge. Inputs change only on falling edges, so registered state has settled by then, and the combinational polarity and enable paths already reflect the current inputs.

// File: rtl/ser_rd_pkg.sv
package ser_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_REL
    } rd_state_e;

endpackage

// File: rtl/ser_rate_sel.sv
module ser_rate_sel #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [SEL_W-1:0] div_sel,
    input  logic             force_fast,
    output logic [CNT_W-1:0] cnt_max
);

    logic [SEL_W-1:0] sel_eff;
    logic [CNT_W:0]   span;

    always_comb begin
        sel_eff = force_fast ? '0 : div_sel;
        span    = ({{CNT_W{1'b0}}, 1'b1} << sel_eff) - 1'b1;
        cnt_max = span[CNT_W-1:0];
    end

endmodule

// File: rtl/ser_edge_gen.sv
module ser_edge_gen #(
    parameter int CNT_W     = 3,
    parameter int HALF_W    = 5,
    parameter int LAST_HALF = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt_max,
    output logic             shift_tick,
    output logic             last_tick,
    output logic             sclk_lvl
);

    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [HALF_W-1:0] half_d, half_q;
    logic              half_end;

    always_comb begin
        half_end   = run && (cnt_q == cnt_max);
        cnt_d      = cnt_q;
        half_d     = half_q;
        if (!run) begin
            cnt_d  = '0;
            half_d = '0;
        end else if (half_end) begin
            cnt_d  = '0;
            half_d = half_q + 1'b1;
        end else begin
            cnt_d  = cnt_q + 1'b1;
        end
        sclk_lvl   = run && half_q[0];
        last_tick  = half_end && (half_q == HALF_W'(LAST_HALF));
        shift_tick = half_end && half_q[0] && (half_q != HALF_W'(LAST_HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            half_q <= half_d;
        end
    end

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != '0) |-> $stable(sclk_lvl)); // R2

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    output logic              msb
);

    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = load_val;
        else if (shift_en)
            sh_d = {sh_q[DATA_W-2:0], 1'b0};
        msb = sh_q[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (msb == $past(sh_q[DATA_W-2]))); // R1

endmodule

// File: rtl/ser_master_rd.sv
module ser_master_rd
    import ser_rd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SEL_W    = 2,
    parameter int SYNC_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result_i,
    input  logic              rd_during,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              sync_inv,
    input  logic              sclk_inv,
    output logic              sync_o,
    output logic              sclk_o,
    output logic              sdout_o,
    output logic              sync_oe,
    output logic              sclk_oe,
    output logic              sdout_oe,
    output logic              hold_busy_o
);

    localparam int CNT_W     = (1 << SEL_W) - 1;
    localparam int LAST_HALF = 2 * DATA_W - 1;
    localparam int HALF_W    = $clog2(2 * DATA_W);
    localparam int DLY_W     = $clog2(SYNC_DLY + 1);

    typedef struct packed {
        rd_state_e         st;
        logic              during;
        logic [CNT_W-1:0]  cmax;
        logic [DLY_W-1:0]  dly;
        logic [DATA_W-1:0] res;
    } rd_regs_t;

    rd_regs_t          q, d;
    logic              load;
    logic [DATA_W-1:0] load_val;
    logic [CNT_W-1:0]  rate_cmax;
    logic              shift_tick, last_tick, sclk_lvl, sh_msb;
    logic              sync_act, in_frame, run;

    ser_rate_sel #(.SEL_W(SEL_W), .CNT_W(CNT_W)) rate_i (
        .div_sel   (div_sel),
        .force_fast(rd_during),
        .cnt_max   (rate_cmax)
    );

    ser_edge_gen #(.CNT_W(CNT_W), .HALF_W(HALF_W), .LAST_HALF(LAST_HALF)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt_max   (q.cmax),
        .shift_tick(shift_tick),
        .last_tick (last_tick),
        .sclk_lvl  (sclk_lvl)
    );

    ser_shift_reg #(.DATA_W(DATA_W)) shreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .shift_en(shift_tick),
        .msb     (sh_msb)
    );

    always_comb begin
        d        = q;
        load     = 1'b0;
        load_val = result_i;
        if (conv_done)
            d.res = result_i;
        unique case (q.st)
            ST_IDLE: begin
                if (rd_during && conv_start) begin
                    d.st     = (SYNC_DLY == 0) ? ST_LEAD : ST_WAIT;
                    d.during = 1'b1;
                    d.cmax   = rate_cmax;
                    d.dly    = '0;
                    load     = 1'b1;
                    load_val = q.res;
                end else if (!rd_during && conv_done) begin
                    d.st     = ST_LEAD;
                    d.during = 1'b0;
                    d.cmax   = rate_cmax;
                    load     = 1'b1;
                    load_val = result_i;
                end
            end
            ST_WAIT: begin
                d.dly = q.dly + 1'b1;
                if (q.dly == DLY_W'(SYNC_DLY - 1))
                    d.st = ST_LEAD;
            end
            ST_LEAD:  d.st = ST_SHIFT;
            ST_SHIFT: if (last_tick) d.st = ST_TAIL;
            ST_TAIL:  d.st = q.during ? ST_IDLE : ST_REL;
            ST_REL:   d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase

        run         = (q.st == ST_SHIFT);
        in_frame    = (q.st == ST_LEAD) || (q.st == ST_SHIFT) || (q.st == ST_TAIL);
        sync_act    = in_frame;
        hold_busy_o = !q.during && (in_frame || q.st == ST_REL);
        sync_o      = sync_act ^ sync_inv;
        sclk_o      = sclk_lvl ^ sclk_inv;
        sdout_o     = in_frame && sh_msb;
        sync_oe     = !cs_n;
        sclk_oe     = !cs_n;
        sdout_oe    = !cs_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.during <= 1'b0;
            q.cmax   <= '0;
            q.dly    <= '0;
            q.res    <= '0;
        end else begin
            q <= d;
        end
    end

    AST_TAIL_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && last_tick) |=> (sync_act && !sclk_lvl)); // R4

    AST_BUSY_PAST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_act) && !q.during) |-> hold_busy_o); // R5

    AST_LEAD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LEAD && q.during) |-> ($past(q.st) == ST_WAIT)); // R3

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && !last_tick) |=> (q.st == ST_SHIFT)); // R8

endmodule

// File: tb/ser_master_rd_tb_top.sv
module ser_master_rd_tb_top;

    localparam int CLK_P    = 10;
    localparam int SYNC_DLY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] result_i = '0;
    logic        rd_during = 1'b0;
    logic [1:0]  div_sel = '0;
    logic        sync_inv = 1'b0;
    logic        sclk_inv = 1'b0;
    logic        sync_o, sclk_o, sdout_o, sync_oe, sclk_oe, sdout_oe, hold_busy_o;

    ser_master_rd #(.DATA_W(16), .SEL_W(2), .SYNC_DLY(SYNC_DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conv_start(conv_start),
        .conv_done(conv_done), .result_i(result_i), .rd_during(rd_during),
        .div_sel(div_sel), .sync_inv(sync_inv), .sclk_inv(sclk_inv),
        .sync_o(sync_o), .sclk_o(sclk_o), .sdout_o(sdout_o),
        .sync_oe(sync_oe), .sclk_oe(sclk_oe), .sdout_oe(sdout_oe),
        .hold_busy_o(hold_busy_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // expected raw values per cycle: {hold, sync, sclk, sdout}
    logic [3:0]  exp_q[$];
    logic [15:0] m_res = '0;
    logic [15:0] m_old;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          done = 0;
    string       cur_tag = "R9";

    task automatic build(input logic [15:0] dv, input int dlog, input bit dur);
        int  per = 1 << dlog;
        logic hb = !dur;
        if (dur)
            for (int i = 0; i < SYNC_DLY; i++) exp_q.push_back(4'b0000);
        exp_q.push_back({hb, 1'b1, 1'b0, dv[15]});
        for (int s = 0; s < 32 * per; s++) begin
            int h = s / per;
            exp_q.push_back({hb, 1'b1, 1'((h % 2) == 1), dv[15 - h / 2]});
        end
        exp_q.push_back({hb, 1'b1, 1'b0, dv[0]});
        if (!dur) exp_q.push_back(4'b1000);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_res = '0;
        end else begin
            m_old = m_res;
            if (exp_q.size() != 0)
                void'(exp_q.pop_front());
            else if (rd_during && conv_start)
                build(m_old, 0, 1'b1);
            else if (!rd_during && conv_done)
                build(result_i, int'(div_sel), 1'b0);
            if (conv_done) m_res = result_i;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(negedge clk) begin
        logic [3:0] e;
        logic [6:0] exp_v, act_v;
        #(CLK_P/4);
        if (!done) begin
            e     = (exp_q.size() != 0) ? exp_q[0] : 4'b0000;
            exp_v = {e[3], e[2] ^ sync_inv, e[1] ^ sclk_inv, e[0], !cs_n, !cs_n, !cs_n};
            act_v = {hold_busy_o, sync_o, sclk_o, sdout_o, sync_oe, sclk_oe, sdout_oe};
            n_chk++;
            if (act_v !== exp_v) begin
                n_fail++;
                $display("FAIL %s t=%0t {busy,sync,sclk,sdo,oe3} actual=%b expected=%b",
                         cur_tag, $time, act_v, exp_v);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic pulse_done(input logic [15:0] v);
        @(negedge clk); result_i = v; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R9: reset state checked while held and after release
        cur_tag = "R9";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1, R4, R5: after-convert frame at full rate
        cur_tag = "R1/R4/R5";
        rd_during = 1'b0; div_sel = 2'd0;
        pulse_done(16'hA5C3);
        wait_idle();

        // R2: slower rates
        cur_tag = "R2";
        for (int k = 1; k < 4; k++) begin
            div_sel = 2'(k);
            pulse_done(16'h9176 ^ 16'(k * 16'h1111));
            wait_idle();
        end

        // R10: conv_done in during mode only stores the result
        cur_tag = "R10";
        rd_during = 1'b1;
        pulse_done(16'h1234);
        repeat (4) @(negedge clk);

        // R3: during-convert frame sends stored word, rate forced fast
        cur_tag = "R3";
        div_sel = 2'd3;
        pulse_start();
        wait_idle();

        // R8: triggers during a frame are ignored; R10 store still updates
        cur_tag = "R8/R10";
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_done(16'hBEEF);
        pulse_start();
        wait_idle();
        pulse_start();
        wait_idle();
        rd_during = 1'b0; div_sel = 2'd0;
        pulse_done(16'h0F0F);
        repeat (5) @(negedge clk);
        pulse_done(16'hFFFF);
        pulse_start();
        wait_idle();

        // R6: polarity inversion
        cur_tag = "R6";
        sync_inv = 1'b1; sclk_inv = 1'b1;
        pulse_done(16'h8001);
        wait_idle();
        sync_inv = 1'b0;
        pulse_done(16'h7FFE);
        wait_idle();
        sclk_inv = 1'b0;

        // R7: chip select gates the enables only
        cur_tag = "R7";
        cs_n = 1'b1;
        pulse_done(16'h3C3C);
        wait_idle();
        cs_n = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule